// File: doc/BRIEF.md
# Bipolar PWM Actuator Output

This block turns a signed command word into a pulse-width-modulated reference for a motor driver. A free-running counter of `CNT_W` bits sets a period of 2^CNT_W clocks. The output stays high for the first D counts of each period, where D is a duty value taken from the command. The counter width is a compile-time parameter, so it fixes both the PWM frequency and the duty resolution together.

There are two output modes, chosen at run time. In offset mode the duty is centred on half scale, so a zero command gives a square wave. The direction pin stays low in this mode. In sign-magnitude mode the duty follows the size of the command and a separate direction pin carries its sign, for drivers that take the direction on its own line.

A command is written into a pending register by a load strobe. The mode input and the pending command take effect only at the wrap of the counter. Every period therefore runs to completion with a single duty value and a single direction, and the output never shows a shortened or split pulse.

Top module: `bipolar_pwm_out`

## Requirements
- R1: The period is 2^CNT_W clocks. The counter starts from 0 after reset. In every period `pwm_o` is high exactly while the count is below the duty value D (0 ≤ D ≤ 2^CNT_W), and low for the rest of the period.
- R2: Offset mode (`dir_mode_i` = 0). D = command + 2^(CNT_W-1). A zero command gives half duty, the most negative command gives D = 0, and a command of -1 gives D = 2^(CNT_W-1) - 1.
- R3: Offset mode. The largest positive command saturates to D = 2^CNT_W, so the output is high for the whole period.
- R4: Sign-magnitude mode (`dir_mode_i` = 1). D = 2·|command|. `dir_o` is 1 for a negative command and 0 for zero or a positive command.
- R5: Sign-magnitude mode. The most negative command saturates to D = 2^CNT_W with `dir_o` = 1.
- R6: In offset mode `dir_o` is 0.
- R7: A new duty, direction and mode take effect only at the counter wrap, from count 2^CNT_W-1 to 0. A load or a mode change during a period leaves the rest of that period unchanged. The mode is sampled at the wrap.
- R8: `cmd_i` is ignored unless `cmd_load_i` is high. The last load before a wrap is the one used. A load in the wrap cycle itself takes effect in the period that then starts.
- R9: While `rst_ni` is low, `pwm_o` and `dir_o` are 0, immediately and asynchronously. After reset the pending command is 0, and the first period is entirely low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | CNT_W | Signed two's-complement command |
| cmd_load_i | input | 1 | Captures `cmd_i` into the pending register |
| dir_mode_i | input | 1 | 0 = offset mode, 1 = sign-magnitude mode |
| pwm_o | output | 1 | PWM reference output |
| dir_o | output | 1 | Direction output (1 = negative) |

## Verification
A command load and the counter wrap can fall on the same clock edge. The block must then pass the fresh command straight into the period that starts, and not the stale pending value. The bench provokes this by pulsing the load strobe exactly in the cycle where the count is at its maximum, changing the mode in that same cycle. It judges the result by the high-time and direction of the following period. It also places loads, mode changes and unstrobed command changes in the middle of a period and checks that the running period keeps its old pattern cycle by cycle.

// File: rtl/bipolar_pwm_pkg.sv
package bipolar_pwm_pkg;
  typedef enum logic {
    PWM_OFFSET  = 1'b0,
    PWM_SIGNMAG = 1'b1
  } pwm_mode_e;
endpackage

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;
  assign wrap_o    = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/pwm_cmd_map.sv
module pwm_cmd_map
  import bipolar_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cmd_i,
  input  pwm_mode_e        mode_i,
  output logic [CNT_W:0]   duty_o,
  output logic             dir_o
);
  localparam logic [CNT_W:0]   FULL    = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W-1:0] MAX_POS = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_NEG = {1'b1, {(CNT_W-1){1'b0}}};

  logic             neg;
  logic [CNT_W-1:0] mag;
  logic [CNT_W:0]   duty_off;
  logic [CNT_W:0]   duty_sm;

  assign neg = cmd_i[CNT_W-1];
  assign mag = neg ? (~cmd_i + 1'b1) : cmd_i;

  // flipping the sign bit adds half scale
  assign duty_off = (cmd_i == MAX_POS) ? FULL
                  : {1'b0, ~cmd_i[CNT_W-1], cmd_i[CNT_W-2:0]};
  // magnitude below 2^(CNT_W-1) except for MIN_NEG, which saturates
  assign duty_sm  = (cmd_i == MIN_NEG) ? FULL : {mag, 1'b0};

  always_comb begin
    if (mode_i == PWM_SIGNMAG) begin
      duty_o = duty_sm;
      dir_o  = neg;
    end else begin
      duty_o = duty_off;
      dir_o  = 1'b0;
    end
  end
endmodule

// File: rtl/bipolar_pwm_out.sv
module bipolar_pwm_out
  import bipolar_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cmd_i,
  input  logic             cmd_load_i,
  input  logic             dir_mode_i,
  output logic             pwm_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] pend_d;
  logic [CNT_W:0]   duty_d;
  logic             dir_d;
  logic [CNT_W:0]   cmp_q;
  logic [CNT_W:0]   cmp_d;
  logic             dir_q;
  pwm_mode_e        mode_q;
  logic             pwm_q;
  logic             pwm_d;

  pwm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  // a load in the wrap cycle bypasses the pending register
  assign pend_d = cmd_load_i ? cmd_i : pend_q;

  pwm_cmd_map #(.CNT_W(CNT_W)) u_map (
    .cmd_i  (pend_d),
    .mode_i (pwm_mode_e'(dir_mode_i)),
    .duty_o (duty_d),
    .dir_o  (dir_d)
  );

  assign cmp_d = wrap ? duty_d : cmp_q;
  assign pwm_d = ({1'b0, cnt_nxt} < cmp_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cmp_q  <= '0;
      dir_q  <= 1'b0;
      mode_q <= PWM_OFFSET;
      pwm_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pwm_q  <= pwm_d;
      if (wrap) begin
        cmp_q  <= duty_d;
        dir_q  <= dir_d;
        mode_q <= pwm_mode_e'(dir_mode_i);
      end
    end
  end

  assign pwm_o = pwm_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/bipolar_pwm_out_chk.sv
module bipolar_pwm_out_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_o,
  input logic             dir_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wrap,
  input logic [CNT_W:0]   cmp_q,
  input logic             mode_q
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R9: assert (!pwm_o && !dir_o);
    end
  end

  assert_rise_at_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (cnt_q == '0));

  assert_full_duty_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == FULL) |-> pwm_o);

  assert_zero_duty_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == '0) |-> !pwm_o);

  assert_dir_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> $past(wrap));

  assert_cmp_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_q) |-> $past(wrap));

  assert_offset_dir_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !dir_o);
endmodule

bind bipolar_pwm_out bipolar_pwm_out_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pwm_o  (pwm_o),
  .dir_o  (dir_o),
  .cnt_q  (cnt_q),
  .wrap   (wrap),
  .cmp_q  (cmp_q),
  .mode_q (mode_q)
);

// File: tb/bipolar_pwm_out_bench.sv
module bipolar_pwm_out_bench;
  localparam int W      = 8;
  localparam int PERIOD = 1 << W;
  localparam int NVEC   = 12;

  // {mode, cmd, expected high count, expected dir}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 9'd128, 1'b0},
    {1'b0, 8'h80, 9'd0,   1'b0},
    {1'b0, 8'h7F, 9'd256, 1'b0},
    {1'b0, 8'h40, 9'd192, 1'b0},
    {1'b0, 8'hFF, 9'd127, 1'b0},
    {1'b0, 8'h7E, 9'd254, 1'b0},
    {1'b1, 8'h00, 9'd0,   1'b0},
    {1'b1, 8'h0A, 9'd20,  1'b0},
    {1'b1, 8'hF6, 9'd20,  1'b1},
    {1'b1, 8'h7F, 9'd254, 1'b0},
    {1'b1, 8'h80, 9'd256, 1'b1},
    {1'b1, 8'hFF, 9'd2,   1'b1}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] cmd_i = '0;
  logic         cmd_load_i = 1'b0;
  logic         dir_mode_i = 1'b0;
  logic         pwm_o;
  logic         dir_o;
  int           checks = 0;
  int           errors = 0;
  int           tb_cyc;
  bit           done = 1'b0;

  always #10 clk_i = ~clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_cyc <= 0;
    else         tb_cyc <= tb_cyc + 1;
  end

  bipolar_pwm_out u_bipolar_pwm_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .cmd_load_i (cmd_load_i),
    .dir_mode_i (dir_mode_i),
    .pwm_o      (pwm_o),
    .dir_o      (dir_o)
  );

  function automatic int cnt_now();
    return tb_cyc % PERIOD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cmd(input logic [W-1:0] c, input logic m);
    dir_mode_i = m;
    cmd_i      = c;
    cmd_load_i = 1'b1;
    @(negedge clk_i);
    cmd_load_i = 1'b0;
    cmd_i      = ~c;
  endtask

  task automatic wait_start();
    while (cnt_now() != 0) @(negedge clk_i);
  endtask

  // kind: 0 none, 1 load poke_cmd, 2 mode to offset, 3 change cmd_i without load
  task automatic measure(input int exp_d, input logic exp_dir, input string req,
                         input int poke_at, input int kind, input logic [W-1:0] poke_cmd);
    int bad = 0;
    int high = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (i == poke_at) begin
        case (kind)
          1: begin cmd_i = poke_cmd; cmd_load_i = 1'b1; end
          2: dir_mode_i = 1'b0;
          3: cmd_i = poke_cmd;
          default: ;
        endcase
      end
      if (i == poke_at + 1) cmd_load_i = 1'b0;
      if (pwm_o) high++;
      if ((pwm_o !== (i < exp_d)) || (dir_o !== exp_dir)) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, req, high, exp_d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check(!pwm_o && !dir_o, "R9 reset state", {30'd0, pwm_o, dir_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    bad = 0;
    while (cnt_now() != 0) begin
      if (pwm_o !== 1'b0) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R9 first period low", bad, 0);
    measure(128, 1'b0, "R2 zero pending after reset", -1, 0, '0);

    // R1 R2 R3 R4 R5 R6 vector walk
    for (int v = 0; v < NVEC; v++) begin
      load_cmd(VEC[v][17:10], VEC[v][18]);
      wait_start();
      measure(int'(VEC[v][9:1]), VEC[v][0],
              VEC[v][18] ? "R1 R4 R5 sign-magnitude" : "R1 R2 R3 R6 offset", -1, 0, '0);
    end

    // R8: unstrobed command change is ignored
    load_cmd(8'h40, 1'b0);
    wait_start();
    measure(192, 1'b0, "R8 loaded", 40, 3, 8'h9C);
    measure(192, 1'b0, "R8 unstrobed cmd ignored", -1, 0, '0);

    // R7: load in mid period does not touch current period
    measure(192, 1'b0, "R7 mid-period load", 100, 1, 8'h80);
    measure(0, 1'b0, "R7 load applied at wrap", -1, 0, '0);

    // R8: load and mode change in the wrap cycle
    while (cnt_now() != PERIOD - 1) @(negedge clk_i);
    load_cmd(8'h0A, 1'b1);
    check(cnt_now() == 0, "R8 wrap alignment", cnt_now(), 0);
    measure(20, 1'b0, "R8 load in wrap cycle", -1, 0, '0);

    // R7: mode change mid period
    load_cmd(8'hF6, 1'b1);
    wait_start();
    measure(20, 1'b1, "R7 R4 negative", 50, 2, '0);
    measure(118, 1'b0, "R7 mode sampled at wrap R6", -1, 0, '0);

    // R9: asynchronous reset while output high and dir set
    load_cmd(8'h80, 1'b1);
    wait_start();
    measure(256, 1'b1, "R5 most negative full", -1, 0, '0);
    #5 rst_ni = 1'b0;
    #1 check(!pwm_o && !dir_o, "R9 async reset", {30'd0, pwm_o, dir_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule